// File: doc/BRIEF.md
# Debug Abstract Register Command Engine

This block carries out register-access commands on behalf of an external debugger attached to a 32-bit hart. The debugger sees three registers on a small read/write bus. The first is a command word. The second is a 32-bit data register, which carries the value in and out. The third is a control/status register, which shows whether a command is running and holds any error code.

When the debugger writes a command that names a general-purpose register or a control/status register of a halted hart, the engine holds a request toward the hart's register file until the hart acknowledges it. On a read, the returned value goes into the data register. Failures leave a sticky error code that the debugger must clear before it can issue another command.

The engine runs through idle, busy, complete and error phases. Only the busy phase is visible to the debugger.

Top module: `dbg_areg_cmd`

## Requirements
- R1: The status register at bus address 0x16 reads as: bits 3:0 = 1 (one data register), bits 28:24 = 0 (no program buffer), bit 12 = busy, bits 10:8 = error code. All other bits read 0. Address 0x17 reads 0.
- R2: The data register at bus address 0x04 is written by the bus and read back unchanged while no command is running.
- R3: The command word, written at 0x17, has these fields: command type in bits 31:24, size in bits 22:20, transfer in bit 17, write in bit 16, and register number in bits 15:0. A type other than 0 or a size other than 2 gives error code 2 and no hart request. This check has the highest priority.
- R4: After an accepted command, busy and hart_req are high from the next cycle up to and including the cycle in which hart_ack is high. While the request is held, hart_we, hart_csr and hart_regno stay constant.
- R5: Register numbers 0x1000 to 0x101F request a general-purpose register (hart_csr=0, hart_regno = number minus 0x1000). Numbers 0x0000 to 0x0FFF request a control/status register (hart_csr=1, hart_regno = number). Any other number with transfer=1 gives error code 2.
- R6: A valid command issued while hart_halted is low gives error code 4 and no hart request. This check comes after the R3 check and before all others.
- R7: A command with transfer=0 completes with no request and no error. A write to register number 0x1000 (x0) completes with no request and no error.
- R8: A read that is acknowledged with no error loads hart_rdata into the data register. A write presents the data register on hart_wdata for the whole request.
- R9: An acknowledge with hart_nocsr high gives error code 2. An acknowledge with hart_exc high (and hart_nocsr low) gives error code 3. In both cases the data register is left unchanged.
- R10: While busy, a bus write to 0x04 or 0x17, or a bus read of 0x04, gives error code 1, and the write has no effect. If a hart error is reported in the same cycle, the hart's code is kept instead.
- R11: A nonzero error code stays until a write to 0x16 with 1s in bits 10:8 clears the matching bits. While the code is nonzero, command writes are ignored. A new code is recorded only when the current code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Debugger write strobe |
| bus_rd | input | 1 | Debugger read strobe |
| bus_addr | input | 7 | Debugger register address |
| bus_wdata | input | 32 | Debugger write data |
| bus_rdata | output | 32 | Debugger read data, combinational from bus_addr |
| hart_halted | input | 1 | Hart is halted |
| hart_req | output | 1 | Register access request, held until acknowledge |
| hart_we | output | 1 | Access is a write |
| hart_csr | output | 1 | Access targets a control/status register |
| hart_regno | output | 12 | Register index within the selected space |
| hart_wdata | output | 32 | Value to write |
| hart_ack | input | 1 | Hart completes the access this cycle |
| hart_exc | input | 1 | Access raised an exception |
| hart_nocsr | input | 1 | Addressed control/status register does not exist |
| hart_rdata | input | 32 | Value read, valid with hart_ack |

## Verification
Two events can fall in the same cycle: the hart's acknowledge that ends a command, and a debugger access that hits the busy engine. The bench tunes the responder latency so that a data-register write lands exactly on the acknowledge cycle. It does this once with a clean read and once with an exception. The behavioural model then decides the outcome. With a clean read, the hart value must win in the data register and error code 1 is recorded. With an exception, code 3 wins and the bus write is dropped.

// File: rtl/dbg_areg_cmd.sv
module dbg_areg_cmd #(
  parameter int AW = 7,
  parameter logic [AW-1:0] A_DATA = 7'h04,
  parameter logic [AW-1:0] A_STAT = 7'h16,
  parameter logic [AW-1:0] A_CMD  = 7'h17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          hart_halted,
  output logic          hart_req,
  output logic          hart_we,
  output logic          hart_csr,
  output logic [11:0]   hart_regno,
  output logic [31:0]   hart_wdata,
  input  logic          hart_ack,
  input  logic          hart_exc,
  input  logic          hart_nocsr,
  input  logic [31:0]   hart_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE, S_FAIL} st_t;

  st_t         st;
  logic [31:0] data0;
  logic [2:0]  cmderr, dec_err, hart_err, set_err, clr_err;
  logic        c_we, c_csr, go;
  logic [11:0] c_idx;

  wire busy    = st == S_BUSY;
  wire sel_dat = bus_addr == A_DATA;
  wire sel_cmd = bus_addr == A_CMD;
  wire sel_st  = bus_addr == A_STAT;

  wire [15:0] f_reg  = bus_wdata[15:0];
  wire        f_wr   = bus_wdata[16];
  wire        f_xfer = bus_wdata[17];
  wire        unsup  = bus_wdata[31:24] != 8'd0 || bus_wdata[22:20] != 3'd2;
  wire        is_gpr = f_reg[15:5] == 11'h080;
  wire        is_csr = f_reg[15:12] == 4'd0;

  wire issue    = bus_wr && sel_cmd && !busy && cmderr == 3'd0;
  wire busy_hit = busy && ((bus_wr && (sel_dat || sel_cmd)) || (bus_rd && sel_dat));

  always_comb begin
    dec_err = 3'd0;
    go      = 1'b0;
    if (unsup)              dec_err = 3'd2;
    else if (!hart_halted)  dec_err = 3'd4;
    else if (f_xfer) begin
      if (!is_gpr && !is_csr)                           dec_err = 3'd2;
      else if (!(is_gpr && f_wr && f_reg[4:0] == 5'd0)) go = 1'b1;
    end
  end

  assign hart_err = !(busy && hart_ack) ? 3'd0 :
                    hart_nocsr ? 3'd2 : hart_exc ? 3'd3 : 3'd0;
  assign set_err  = hart_err != 3'd0 ? hart_err :
                    busy_hit ? 3'd1 : issue ? dec_err : 3'd0;
  assign clr_err  = (bus_wr && sel_st) ? bus_wdata[10:8] : 3'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cmderr <= 3'd0;
      data0  <= 32'd0;
      c_we   <= 1'b0;
      c_csr  <= 1'b0;
      c_idx  <= 12'd0;
    end else begin
      if (cmderr == 3'd0 && set_err != 3'd0) cmderr <= set_err;
      else                                   cmderr <= cmderr & ~clr_err;

      if (busy) begin
        if (hart_ack) begin
          st <= (hart_err != 3'd0) ? S_FAIL : S_DONE;
          if (!c_we && hart_err == 3'd0) data0 <= hart_rdata;
        end
      end else begin
        if (bus_wr && sel_dat) data0 <= bus_wdata;
        if (issue) begin
          st <= go ? S_BUSY : (dec_err != 3'd0 ? S_FAIL : S_DONE);
          if (go) begin
            c_we  <= f_wr;
            c_csr <= !is_gpr;
            c_idx <= is_gpr ? {7'd0, f_reg[4:0]} : f_reg[11:0];
          end
        end else begin
          st <= S_IDLE;
        end
      end
    end
  end

  assign hart_req   = busy;
  assign hart_we    = c_we;
  assign hart_csr   = c_csr;
  assign hart_regno = c_idx;
  assign hart_wdata = data0;

  always_comb begin
    bus_rdata = 32'd0;
    if (sel_dat)     bus_rdata = data0;
    else if (sel_st) bus_rdata = {19'd0, busy, 1'b0, cmderr, 4'd0, 4'd1};
  end
endmodule

// File: rtl/dbg_areg_cmd_chk.sv
module dbg_areg_cmd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [6:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        hart_halted,
  input logic        hart_req,
  input logic        hart_we,
  input logic        hart_csr,
  input logic [11:0] hart_regno,
  input logic        hart_ack,
  input logic        hart_exc,
  input logic        hart_nocsr,
  input logic [2:0]  cmderr
);
  a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    hart_req && !hart_ack |=> hart_req);

  a_r4_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    hart_req && !hart_ack |=> $stable(hart_we) && $stable(hart_csr) && $stable(hart_regno));

  a_r6_halt_needed: assert property (@(posedge clk) disable iff (!rst_n)
    !hart_req && !hart_halted |=> !hart_req);

  a_r9_exception_code: assert property (@(posedge clk) disable iff (!rst_n)
    hart_req && hart_ack && hart_exc && !hart_nocsr && cmderr == 3'd0 |=> cmderr == 3'd3);

  a_r10_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    hart_req && !hart_ack && bus_wr && bus_addr == 7'h04 && cmderr == 3'd0 |=> cmderr == 3'd1);

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cmderr != 3'd0 && !(bus_wr && bus_addr == 7'h16) |=> cmderr == $past(cmderr));

  a_r11_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
    !hart_req && cmderr != 3'd0 |=> !hart_req);
endmodule

bind dbg_areg_cmd dbg_areg_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .hart_halted(hart_halted), .hart_req(hart_req), .hart_we(hart_we), .hart_csr(hart_csr),
  .hart_regno(hart_regno), .hart_ack(hart_ack), .hart_exc(hart_exc),
  .hart_nocsr(hart_nocsr), .cmderr(cmderr)
);

// File: tb/dbg_areg_cmd_tb.sv
`timescale 1ns/1ps
module dbg_areg_cmd_tb;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [6:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic hart_halted = 1;
  logic hart_req, hart_we, hart_csr;
  logic [11:0] hart_regno;
  logic [31:0] hart_wdata;
  logic hart_ack = 0, hart_exc = 0, hart_nocsr = 0;
  logic [31:0] hart_rdata = 0;

  always #4 clk = ~clk;

  dbg_areg_cmd u_dut (.*);

  int vecs = 0, fails = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  // hart register file model
  logic [31:0] gprs [32];
  logic [31:0] csr_mstatus = 32'h0000_1800, csr_misa = 32'h4000_0100;
  int lat = 0, cnt = 0;
  bit r_exc = 0;

  always @(negedge clk) begin
    if (hart_req && !hart_ack) begin
      if (cnt >= lat) begin
        cnt = 0;
        hart_ack <= 1;
        hart_exc <= r_exc;
        if (hart_csr) begin
          hart_nocsr <= !(hart_regno == 12'h300 || hart_regno == 12'h301);
          hart_rdata <= hart_regno == 12'h300 ? csr_mstatus : csr_misa;
          if (hart_we && !r_exc && hart_regno == 12'h300) csr_mstatus <= hart_wdata;
        end else begin
          hart_nocsr <= 0;
          hart_rdata <= gprs[hart_regno[4:0]];
          if (hart_we && !r_exc) gprs[hart_regno[4:0]] <= hart_wdata;
        end
      end else cnt++;
    end else begin
      hart_ack <= 0; hart_exc <= 0; hart_nocsr <= 0;
    end
  end

  // behavioural reference model
  bit m_busy, m_we, m_csr;
  int m_idx, m_err, setv, clrv, rg;
  logic [31:0] m_d0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_we = 0; m_csr = 0; m_idx = 0; m_err = 0; m_d0 = 0;
    end else begin
      setv = 0; clrv = 0;
      if (m_busy) begin
        if (hart_ack) begin
          if (hart_nocsr) setv = 2;
          else if (hart_exc) setv = 3;
          else if (!m_we) m_d0 = hart_rdata;
          m_busy = 0;
        end
        if (setv == 0 && ((bus_wr && (bus_addr == 7'h04 || bus_addr == 7'h17)) ||
                          (bus_rd && bus_addr == 7'h04))) setv = 1;
      end else begin
        if (bus_wr && bus_addr == 7'h04) m_d0 = bus_wdata;
        if (bus_wr && bus_addr == 7'h17 && m_err == 0) begin
          rg = int'(bus_wdata[15:0]);
          if (bus_wdata[31:24] != 0 || bus_wdata[22:20] != 3'd2) setv = 2;
          else if (!hart_halted) setv = 4;
          else if (bus_wdata[17]) begin
            if (rg >= 'h1000 && rg <= 'h101f) begin
              if (!(bus_wdata[16] && rg == 'h1000)) begin
                m_busy = 1; m_we = bus_wdata[16]; m_csr = 0; m_idx = rg - 'h1000;
              end
            end else if (rg <= 'hfff) begin
              m_busy = 1; m_we = bus_wdata[16]; m_csr = 1; m_idx = rg;
            end else setv = 2;
          end
        end
      end
      if (bus_wr && bus_addr == 7'h16) clrv = int'(bus_wdata[10:8]);
      if (m_err == 0 && setv != 0) m_err = setv;
      else m_err = m_err & ~clrv;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4 hart_req vs model", 32'(hart_req), 32'(m_busy));
      if (m_busy) begin
        chk("R5 hart_csr", 32'(hart_csr), 32'(m_csr));
        chk("R5 hart_regno", 32'(hart_regno), 32'(m_idx));
        chk("R4 hart_we", 32'(hart_we), 32'(m_we));
        if (m_we) chk("R8 hart_wdata", hart_wdata, m_d0);
      end
    end
  end

  task automatic bwr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic brd(logic [6:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 v = bus_rdata;
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!hart_req) break;
    end
    @(negedge clk);
  endtask

  task automatic cmd(logic [31:0] c);
    bwr(7'h17, c); wait_idle();
  endtask

  function automatic logic [31:0] mk(bit xfer, bit wr, logic [15:0] r);
    return (32'd2 << 20) | (32'(xfer) << 17) | (32'(wr) << 16) | 32'(r);
  endfunction

  function automatic logic [31:0] stat(bit b, int e);
    return (32'(b) << 12) | (32'(e) << 8) | 32'd1;
  endfunction

  task automatic expect_stat(string tag, int e);
    logic [31:0] v;
    brd(7'h16, v); chk(tag, v, stat(0, e));
  endtask

  task automatic clear();
    bwr(7'h16, 32'h0000_0700);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 32; i++) gprs[i] = 32'h1000_0000 + 32'(i * 7);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    expect_stat("R1 status after reset", 0);
    brd(7'h04, v); chk("R2 data0 after reset", v, 0);
    brd(7'h17, v); chk("R1 command reads zero", v, 0);
    chk("R4 no request after reset", 32'(hart_req), 0);

    bwr(7'h04, 32'h1234_5678);
    brd(7'h04, v); chk("R2 data0 readback", v, 32'h1234_5678);

    gprs[5] = 32'hA5A5_0005;
    cmd(mk(1, 0, 16'h1005));
    brd(7'h04, v); chk("R8 read x5", v, 32'hA5A5_0005);
    expect_stat("R4 idle after read", 0);

    bwr(7'h04, 32'hCAFE_F00D);
    cmd(mk(1, 1, 16'h1007));
    chk("R8 x7 written", gprs[7], 32'hCAFE_F00D);

    lat = 3;
    cmd(mk(1, 0, 16'h1001));
    brd(7'h04, v); chk("R4 read x1 slow hart", v, gprs[1]);
    lat = 0;

    cmd(mk(1, 0, 16'h0301));
    brd(7'h04, v); chk("R5 read misa", v, 32'h4000_0100);

    cmd(mk(1, 0, 16'h07B0));
    expect_stat("R9 missing CSR code 2", 2);
    brd(7'h04, v); chk("R9 data0 kept", v, 32'h4000_0100);

    cmd(mk(1, 0, 16'h1003));
    brd(7'h04, v); chk("R11 command ignored while error", v, 32'h4000_0100);
    expect_stat("R11 error sticky", 2);
    bwr(7'h16, 32'h0000_0100);
    expect_stat("R11 partial clear keeps code", 2);
    bwr(7'h16, 32'h0000_0200);
    expect_stat("R11 write one clears", 0);

    r_exc = 1;
    bwr(7'h04, 32'h0000_00AA);
    cmd(mk(1, 1, 16'h0300));
    r_exc = 0;
    expect_stat("R9 exception code 3", 3);
    chk("R9 mstatus untouched", csr_mstatus, 32'h0000_1800);
    clear();

    hart_halted = 0;
    cmd(mk(1, 0, 16'h1002));
    expect_stat("R6 not halted code 4", 4);
    clear();
    cmd(mk(0, 0, 16'h1002));
    expect_stat("R6 not halted without transfer", 4);
    clear();
    hart_halted = 1;

    cmd(32'h0100_0000 | mk(1, 0, 16'h1002));
    expect_stat("R3 bad command type", 2);
    clear();
    cmd((32'd3 << 20) | (32'd1 << 17) | 32'h1002);
    expect_stat("R3 bad size", 2);
    clear();
    cmd(mk(1, 0, 16'h1020));
    expect_stat("R5 number past GPRs", 2);
    clear();
    cmd(mk(1, 0, 16'hC000));
    expect_stat("R5 number out of range", 2);
    clear();

    bwr(7'h04, 32'h0BAD_0BAD);
    cmd(mk(0, 1, 16'h1004));
    expect_stat("R7 no transfer no error", 0);
    chk("R7 x4 untouched", gprs[4], 32'h1000_001C);
    cmd(mk(1, 1, 16'h1000));
    expect_stat("R7 x0 write no error", 0);
    brd(7'h04, v); chk("R7 data0 after x0 write", v, 32'h0BAD_0BAD);

    lat = 4;
    bwr(7'h17, mk(1, 0, 16'h1006));
    bwr(7'h04, 32'hDEAD_BEEF);
    wait_idle();
    expect_stat("R10 busy write code 1", 1);
    brd(7'h04, v); chk("R10 busy write dropped", v, gprs[6]);
    clear();

    bwr(7'h17, mk(1, 0, 16'h1008));
    bwr(7'h17, mk(1, 0, 16'h1009));
    wait_idle();
    expect_stat("R10 busy command code 1", 1);
    brd(7'h04, v); chk("R10 first command result", v, gprs[8]);
    clear();

    lat = 2;
    bwr(7'h17, mk(1, 0, 16'h100A));
    @(negedge clk); @(negedge clk);
    bwr(7'h04, 32'h5555_5555);
    wait_idle();
    brd(7'h04, v); chk("R10 ack collision hart wins data0", v, gprs[10]);
    expect_stat("R10 ack collision code 1", 1);
    clear();

    r_exc = 1;
    bwr(7'h17, mk(1, 0, 16'h100B));
    @(negedge clk); @(negedge clk);
    bwr(7'h04, 32'h6666_6666);
    wait_idle();
    r_exc = 0;
    expect_stat("R10 exception beats busy code", 3);
    brd(7'h04, v); chk("R10 collision data0 kept", v, gprs[10]);
    clear();
    lat = 0;

    repeat (3) @(negedge clk);
    report();
  end
endmodule